// File: doc/BRIEF.md
# Down-Counting Event Timer with Shadowed Count

This block is a single-channel event timer that sits on a plain 32-bit register bus. Software places a reload value in two load words, sets a control word, and the timer counts down one step per clock from that value. When the count is found at zero while the timer runs, an expiry event occurs. In periodic mode the counter refills itself from the load words and keeps going. In one-shot mode it parks at zero. Each expiry latches a raw interrupt flag. That flag, gated by an interrupt enable, drives the `irq` output. Software removes the flag by writing a 1 to a clear bit.

The counter works as 32 or 64 bits. In narrow mode the upper load word is disregarded and the upper count word reads as zero. Because the count only falls, the bitwise inverse of the live value works as an up-counting time base. The live count can be read directly. A shadow pair gives a tear-free 64-bit sample: reading the low shadow word returns the live low word and freezes the upper word at the same instant, so a later read of the high shadow word matches it. Accesses use a valid/write/address strobe. The address is a byte address, and only word-aligned accesses are decoded.

Top module: `evt_timer`

## Requirements
- R1: After reset every readable word is zero, the counter is stopped at zero and `irq` is low.
- R2: The load words (low at 0x00, high at 0x04) read back what was written. The control word at 0x10 reads back bit 0 (periodic), bit 1 (enable) and bit 16 (64-bit width), and all its other bits read zero. Word 0x14 reads back the interrupt enable in bit 0. Its bit 3 (clear) always reads zero.
- R3: On the first clock edge at which enable is seen set after being clear, the counter takes the load value. In 64-bit mode that value is {high, low}. The counter then falls by one on each later edge while enable stays set. The live count reads as low word at 0x08 and high word at 0x0C.
- R4: When the running counter is at zero on a clock edge, an expiry occurs and the raw status (bit 1 of 0x14) is set by that edge. With load value N, the first expiry is N+2 edges after the edge that wrote enable.
- R5: In periodic mode an expiry reloads the counter from the load words, so expiries recur every N+1 edges.
- R6: In one-shot mode the counter stays at zero after an expiry, and no further expiry occurs until enable is cleared and set again. Re-arming gives a fresh expiry N+2 edges after the enabling write.
- R7: With bit 16 clear, only the low load word is used and the high count word reads zero. Expiry follows the low 32 bits alone.
- R8: Masked status (bit 2 of 0x14) equals raw status AND interrupt enable, and `irq` equals masked status.
- R9: Writing 0x14 with bit 3 set clears the raw status. Writing 0x14 with bit 3 clear leaves the raw status as it was. An expiry on the same edge as a clear wins, and the flag stays set.
- R10: While enable is clear the counter holds its value and no expiry occurs.
- R11: A read of 0x18 returns the live low count and captures the high count word. A later read of 0x1C returns that captured word, even after the live high word has changed.
- R12: Writes to the read-only words (0x08, 0x0C, 0x18, 0x1C) and accesses whose address bits [1:0] are non-zero have no effect, and a misaligned read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| irq | output | 1 | Interrupt request, equal to masked status |

## Verification
The bench checks the exact edge of the first expiry and of each periodic repeat. A reload that slipped by one cycle, or an off-by-one at zero, would move the interrupt by a poll. It clears the flag on an edge where a zero-load periodic timer also expires, and a design where clear wins would show the flag low. It reads the high shadow word after the live high word has fallen across a 32-bit boundary, so a shadow that tracked the live count would return the new value. It also re-arms a one-shot timer and pokes read-only and misaligned addresses. A timer that fired again while parked, or stored a stray write, would then show a wrong flag or a wrong word.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  typedef enum logic [IDX_W-1:0] {
    REG_LOAD_LO = 3'd0,
    REG_LOAD_HI = 3'd1,
    REG_VAL_LO  = 3'd2,
    REG_VAL_HI  = 3'd3,
    REG_CTRL    = 3'd4,
    REG_IRQ     = 3'd5,
    REG_SHD_LO  = 3'd6,
    REG_SHD_HI  = 3'd7
  } reg_idx_e;

  localparam int unsigned CTL_PERIODIC_BIT = 0;
  localparam int unsigned CTL_ENABLE_BIT   = 1;
  localparam int unsigned CTL_WIDE_BIT     = 16;

  localparam int unsigned IRQ_EN_BIT  = 0;
  localparam int unsigned IRQ_RAW_BIT = 1;
  localparam int unsigned IRQ_MSK_BIT = 2;
  localparam int unsigned IRQ_CLR_BIT = 3;

  typedef struct packed {
    logic wide;
    logic enable;
    logic periodic;
  } ctrl_t;

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  reg_idx_e        wr_idx,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] load,
  output ctrl_t           ctrl,
  output logic            ien,
  output logic            clr_req
);

  localparam int unsigned NW = 2;

  // load words, one register per half
  for (genvar w = 0; w < NW; w++) begin : g_load
    localparam reg_idx_e SLOT = (w == 0) ? REG_LOAD_LO : REG_LOAD_HI;
    logic [DW-1:0] word_q;
    logic          word_we;

    assign word_we = wr_en && (wr_idx == SLOT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_we) begin
        word_q <= wdata;
      end
    end

    assign load[w*DW +: DW] = word_q;
  end

  // control word
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_we;

  always_comb begin
    ctrl_we        = wr_en && (wr_idx == REG_CTRL);
    ctrl_d.wide     = wdata[CTL_WIDE_BIT];
    ctrl_d.enable   = wdata[CTL_ENABLE_BIT];
    ctrl_d.periodic = wdata[CTL_PERIODIC_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  // interrupt enable and clear strobe
  logic ien_q, ien_we;

  assign ien_we  = wr_en && (wr_idx == REG_IRQ);
  assign clr_req = ien_we && wdata[IRQ_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
    end else if (ien_we) begin
      ien_q <= wdata[IRQ_EN_BIT];
    end
  end

  assign ctrl = ctrl_q;
  assign ien  = ien_q;

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
  import evt_timer_pkg::*;
#(
  parameter int unsigned CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [CW-1:0] load,
  output logic [CW-1:0] value,
  output logic          expire
);

  localparam int unsigned HW = CW / 2;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          en_q, done_q, done_d;
  logic [CW-1:0] cur, ld;
  logic          start, run, cnt_we;

  // narrow mode masks the upper half of both count and load
  assign cur = ctrl.wide ? cnt_q : {{HW{1'b0}}, cnt_q[HW-1:0]};
  assign ld  = ctrl.wide ? load  : {{HW{1'b0}}, load[HW-1:0]};

  assign start  = ctrl.enable && !en_q;
  assign run    = ctrl.enable && en_q && !done_q;
  assign expire = run && (cur == '0);
  assign cnt_we = start || run;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (start) begin
      cnt_d  = ld;
      done_d = 1'b0;
    end else if (expire) begin
      cnt_d  = ctrl.periodic ? ld : cur;
      done_d = !ctrl.periodic;
    end else if (run) begin
      cnt_d  = cur - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      en_q   <= ctrl.enable;
      done_q <= done_d;
    end
  end

  assign value = cur;

  AST_LOAD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == $past(ld)));                                  // R3
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cur != '0)) |=> (cnt_q == $past(cur) - ONE));             // R3
  AST_ONESHOT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && en_q && ctrl.enable) |=> $stable(cnt_q));               // R6
  AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.enable |=> $stable(cnt_q));                                  // R10

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_req,
  input  logic ien,
  output logic raw,
  output logic masked
);

  logic raw_q, raw_d;

  // an expiry on the clearing edge keeps the flag
  always_comb begin
    raw_d = raw_q;
    if (clr_req) raw_d = 1'b0;
    if (expire)  raw_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
    end
  end

  assign raw    = raw_q;
  assign masked = raw_q && ien;

  AST_EXPIRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_q);                                                 // R4
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !raw_q);                                  // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !clr_req) |=> raw_q);                                    // R9

endmodule

// File: rtl/evt_timer_shadow.sv
module evt_timer_shadow #(
  parameter int unsigned HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [HW-1:0] value_hi,
  output logic [HW-1:0] shadow_hi
);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (capture) begin
      hold_q <= value_hi;
    end
  end

  assign shadow_hi = hold_q;

  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (hold_q == $past(value_hi)));                          // R11
  AST_SHADOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(hold_q));                                     // R11

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);

  localparam int unsigned CW = 2 * DW;

  reg_idx_e        idx;
  logic            aligned, wr_en, rd_en, capture;
  logic [CW-1:0]   load, value;
  ctrl_t           ctrl;
  logic            ien, clr_req, expire, raw, masked;
  logic [DW-1:0]   shadow_hi;
  logic [DW-1:0]   rdata_d;

  assign idx     = reg_idx_e'(bus_addr[ADDR_W-1:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_en   = bus_valid && aligned && bus_write;
  assign rd_en   = bus_valid && aligned && !bus_write;
  assign capture = rd_en && (idx == REG_SHD_LO);

  evt_timer_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wdata   (bus_wdata),
    .load    (load),
    .ctrl    (ctrl),
    .ien     (ien),
    .clr_req (clr_req)
  );

  evt_timer_core #(.CW(CW)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl),
    .load   (load),
    .value  (value),
    .expire (expire)
  );

  evt_timer_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .clr_req (clr_req),
    .ien     (ien),
    .raw     (raw),
    .masked  (masked)
  );

  evt_timer_shadow #(.HW(DW)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .value_hi  (value[CW-1:DW]),
    .shadow_hi (shadow_hi)
  );

  always_comb begin
    rdata_d = '0;
    if (rd_en) begin
      unique case (idx)
        REG_LOAD_LO: rdata_d = load[DW-1:0];
        REG_LOAD_HI: rdata_d = load[CW-1:DW];
        REG_VAL_LO:  rdata_d = value[DW-1:0];
        REG_VAL_HI:  rdata_d = value[CW-1:DW];
        REG_CTRL: begin
          rdata_d[CTL_PERIODIC_BIT] = ctrl.periodic;
          rdata_d[CTL_ENABLE_BIT]   = ctrl.enable;
          rdata_d[CTL_WIDE_BIT]     = ctrl.wide;
        end
        REG_IRQ: begin
          rdata_d[IRQ_EN_BIT]  = ien;
          rdata_d[IRQ_RAW_BIT] = raw;
          rdata_d[IRQ_MSK_BIT] = masked;
        end
        REG_SHD_LO:  rdata_d = value[DW-1:0];
        REG_SHD_HI:  rdata_d = shadow_hi;
        default:     rdata_d = '0;
      endcase
    end
  end

  assign bus_rdata = rdata_d;
  assign irq       = masked;

  AST_MISALIGNED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !aligned) |=> $stable(load));           // R12
  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (idx == REG_VAL_LO || idx == REG_SHD_HI)) |=> $stable(load)); // R12

endmodule

// File: tb/tb_evt_timer.sv
`timescale 1ns/1ps
module tb_evt_timer;

  logic        clk, rst_n;
  logic        bus_valid, bus_write;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  localparam logic [4:0] A_LLO = 5'h00, A_LHI = 5'h04, A_VLO = 5'h08, A_VHI = 5'h0C,
                         A_CTL = 5'h10, A_INT = 5'h14, A_SLO = 5'h18, A_SHI = 5'h1C;

  evt_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // expected-value helpers derived from the requirements
  function automatic int first_poll(input int n);  return n + 2; endfunction
  function automatic int repeat_poll(input int n); return n - 1; endfunction
  function automatic logic [31:0] irq_word(input logic en, input logic rw);
    return {29'd0, rw & en, rw, en};
  endfunction
  function automatic logic [31:0] ctrl_word(input logic wide, input logic en, input logic per);
    return (32'(wide) << 16) | (32'(en) << 1) | 32'(per);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_raw(input int lim, output int j, output logic [31:0] d);
    j = -1;
    for (int k = 0; k < lim; k++) begin
      rd(A_INT, d);
      if (d[1]) begin
        j = k;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, v1;
    int j;
    int n;
    logic wide, per;
    logic [31:0] hi;

    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), d);
      check("R1 reset word", d, 0);
    end
    check("R1 irq low", irq, 0);

    // R2 read-back
    wr(A_LLO, 32'hA5A5_0003);
    wr(A_LHI, 32'h1234_5678);
    rd(A_LLO, d); check("R2 load lo", d, 32'hA5A5_0003);
    rd(A_LHI, d); check("R2 load hi", d, 32'h1234_5678);
    wr(A_CTL, 32'hFFFF_FFFD);
    rd(A_CTL, d); check("R2 ctrl bits", d, ctrl_word(1, 0, 1));
    wr(A_CTL, 0);
    wr(A_INT, 32'hFFFF_FFF7);
    rd(A_INT, d); check("R2 int enable", d, irq_word(1, 0));
    wr(A_INT, 0);

    // R12 read-only and misaligned accesses
    wr(A_VLO, 32'hDEAD_BEEF);
    wr(A_VHI, 32'hDEAD_BEEF);
    wr(A_SHI, 32'hDEAD_BEEF);
    wr(5'h01, 32'hFFFF_FFFF);
    rd(A_VLO, d); check("R12 value lo untouched", d, 0);
    rd(A_SHI, d); check("R12 shadow untouched", d, 0);
    rd(A_LLO, d); check("R12 misaligned write ignored", d, 32'hA5A5_0003);
    rd(5'h05, d); check("R12 misaligned read zero", d, 0);

    // R3 / R11 64-bit load and shadow across a word boundary
    wr(A_LHI, 32'd7);
    wr(A_LLO, 32'd2);
    wr(A_CTL, ctrl_word(1, 1, 0));
    idle(1);
    rd(A_SLO, d); check("R3 R11 loaded low via shadow lo", d, 2);
    idle(3);
    rd(A_SHI, d); check("R11 shadow hi consistent", d, 7);
    rd(A_VHI, d); check("R3 live hi after borrow", d, 6);
    rd(A_VLO, d); check("R3 live lo decrement", d, 32'hFFFF_FFFC);

    // R10 freeze
    wr(A_CTL, ctrl_word(1, 0, 0));
    rd(A_VLO, v1);
    idle(5);
    rd(A_VLO, d); check("R10 frozen count", d, v1);
    wr(A_VLO, 32'h0);
    rd(A_VLO, d); check("R12 frozen count after ro write", d, v1);
    rd(A_INT, d); check("R10 no expiry when idle", d, irq_word(0, 0));

    // R4 / R7 / R8 narrow one-shot with a junk high word
    wr(A_LHI, 32'h0000_FFFF);
    wr(A_LLO, 32'd3);
    wr(A_CTL, ctrl_word(0, 1, 0));
    wait_raw(100, j, d);
    check("R4 R7 first expiry edge", j, first_poll(3));
    check("R8 masked low with enable off", d, irq_word(0, 1));
    check("R8 irq low with enable off", irq, 0);
    rd(A_VHI, d); check("R7 high count reads zero", d, 0);
    wr(A_INT, 32'h1);
    rd(A_INT, d); check("R8 masked follows enable", d, irq_word(1, 1));
    check("R8 irq high", irq, 1);
    wr(A_INT, 32'h1);
    rd(A_INT, d); check("R9 write without clear keeps flag", d, irq_word(1, 1));
    wr(A_INT, 32'h9);
    rd(A_INT, d); check("R9 clear drops flag", d, irq_word(1, 0));
    check("R9 irq low after clear", irq, 0);

    // R6 one-shot stays parked, then re-arms
    idle(10);
    rd(A_INT, d); check("R6 no second expiry", d, irq_word(1, 0));
    rd(A_VLO, d); check("R6 parked at zero", d, 0);
    wr(A_CTL, 0);
    wr(A_CTL, ctrl_word(0, 1, 0));
    wait_raw(100, j, d);
    check("R6 re-armed expiry edge", j, first_poll(3));

    // R9 expiry beats clear on the same edge
    wr(A_CTL, 0);
    wr(A_LLO, 32'd0);
    wr(A_CTL, ctrl_word(0, 1, 1));
    idle(3);
    wr(A_INT, 32'h9);
    rd(A_INT, d); check("R9 expiry wins over clear", d, irq_word(1, 1));

    // R5 periodic repeat
    wr(A_CTL, 0);
    wr(A_INT, 32'h9);
    wr(A_LLO, 32'd6);
    wr(A_CTL, ctrl_word(0, 1, 1));
    wait_raw(100, j, d);
    check("R5 first periodic expiry", j, first_poll(6));
    wr(A_INT, 32'h9);
    wait_raw(100, j, d);
    check("R5 periodic repeat", j, repeat_poll(6));

    // random mix
    void'($urandom(32'h0000_5EED));
    for (int it = 0; it < 12; it++) begin
      n    = $urandom_range(2, 40);
      wide = 1'($urandom_range(0, 1));
      per  = 1'($urandom_range(0, 1));
      hi   = wide ? 32'd0 : $urandom;
      wr(A_CTL, 0);
      wr(A_INT, 32'h9);
      wr(A_LLO, 32'(n));
      wr(A_LHI, hi);
      wr(A_CTL, ctrl_word(wide, 1, per));
      wait_raw(100, j, d);
      check("R4 random first expiry", j, first_poll(n));
      check("R8 random irq", irq, 1);
      wr(A_INT, 32'h9);
      if (per) begin
        wait_raw(100, j, d);
        check("R5 random repeat", j, repeat_poll(n));
      end else begin
        idle(n + 5);
        rd(A_INT, d); check("R6 random one-shot quiet", d, irq_word(1, 0));
        rd(A_VLO, d); check("R6 random parked", d, 0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule